// File: doc/BRIEF.md
# Field-Based Luma Noise Level Estimator

This block measures how noisy a luma stream is and reports a 4-bit noise figure (0 for clean video, up to 15 for very noisy video) once per field. Within a programmable rectangle it groups pixels into blocks of four. For each block it adds up the absolute differences between every pixel and the pixel just before it on the same line. In flat picture areas these block sums are dominated by noise.

The figure is not computed directly. It is a tracked boundary. Each candidate interval of block sums starts at its own index, and its width grows with a programmable gain. During a field the block counts only two intervals: the one at the current boundary and the one directly below it. At the field boundary the figure steps by at most one toward the lowest interval that still holds a wanted number of blocks. Two more counters run alongside. A detail counter counts pixel-to-pixel differences that fall in a programmable band. A grey counter counts blocks whose luma sum lies in a mid-range band. When too few grey blocks occur, the estimate uses every block instead of only the grey ones.

The stream carries a field marker (`fsync`), a line marker (`lsync`) and qualified pixels. The configuration inputs must stay stable through a field and through the `fsync` that closes it.

Top module: `luma_noise_estimator`

## Requirements
- R1: Only valid pixels contribute to blocks or to the detail count, and only those inside the window. A pixel is inside when its horizontal index `h` (0-based count of valid pixels since the last `lsync`) lies in [`win_h0`, `win_h1`] and its line index `v` (0 for the first `lsync` after `fsync`) lies in [`win_v0`, `win_v1`]. Pixels that arrive before the first `lsync` of a field are ignored.
- R2: On each line, in-window pixels are grouped four at a time, starting from the first in-window pixel. The first group of every line is dropped, and so is a trailing group with fewer than four pixels. The estimate of a block is the sum of |y − y_prev| over its four pixels, where y_prev is the previous valid pixel on the same line.
- R3: Interval k covers block estimates e with k ≤ e ≤ k + 1 + floor(k·`up_gain`/4), bounds included. During a field, blocks are counted for interval `noise_fig` and, when `noise_fig` > 0, for interval `noise_fig`−1.
- R4: A block is grey when the sum of its four luma values lies in [`grey_lo`, `grey_hi`]. On `fsync`, `grey_cnt` takes the number of grey blocks from the field just closed. If that number is at least `grey_min`, only grey blocks count toward the decision. Otherwise all blocks count.
- R5: On `fsync`, the figure is first tested for a decrement: if `noise_fig` > 0 and the count for the interval below is at least `wanted`, `noise_fig` decrements. Failing that, if the count for the current interval is below `wanted`, it increments. Otherwise it holds.
- R6: `noise_fig` never goes above 15 and never goes below 0, and it never wraps around.
- R7: The detail counter counts in-window pixels whose position inside the window on their line is 4 or more and whose |y − y_prev| lies in [`det_lo`, `det_hi`]. It saturates at 65535, and on `fsync` its value is copied to `detail_cnt`.
- R8: `noise_fig`, `detail_cnt` and `grey_cnt` change only on the clock edge where `fsync` is high. That same edge clears every per-field counter.
- R9: After reset, `noise_fig`, `detail_cnt` and `grey_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Field boundary pulse: closes the current field and opens the next |
| lsync | input | 1 | Line start pulse, given before the first pixel of a line |
| pix_vld | input | 1 | Pixel qualifier |
| pix_y | input | 8 | Luma value |
| win_h0 | input | 11 | First horizontal index of the window |
| win_h1 | input | 11 | Last horizontal index of the window |
| win_v0 | input | 10 | First line of the window |
| win_v1 | input | 10 | Last line of the window |
| up_gain | input | 4 | Interval width gain |
| wanted | input | 16 | Block count an interval must reach |
| det_lo | input | 8 | Detail band lower bound |
| det_hi | input | 8 | Detail band upper bound |
| grey_lo | input | 10 | Grey band lower bound on the 4-pixel luma sum |
| grey_hi | input | 10 | Grey band upper bound on the 4-pixel luma sum |
| grey_min | input | 16 | Grey block count at or above which only grey blocks are used |
| noise_fig | output | 4 | Current noise figure |
| detail_cnt | output | 16 | Detail count of the last closed field |
| grey_cnt | output | 16 | Grey block count of the last closed field |

## Verification
A wrong block grouping, window compare or interval bound does not show at once. It changes the interval counts, and those become visible only as a wrong step of `noise_fig` at the next `fsync`. The bench therefore compares all three outputs at every field boundary against a field-by-field model. A wrong grey or detail count is visible in the very field it occurs. A wrong step in the figure persists, because every later field counts around the wrong boundary, so one bad decision usually shows as a mismatch in the fields that follow. Long runs of fields with an unreachable or trivially met wanted count drive the figure into both clamps.

// File: rtl/luma_noise_estimator.sv
module luma_noise_estimator #(
  parameter int YW = 8,
  parameter int HW = 11,
  parameter int VW = 10,
  parameter int CW = 16,
  parameter int FW = 4,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          lsync,
  input  logic          pix_vld,
  input  logic [YW-1:0] pix_y,
  input  logic [HW-1:0] win_h0,
  input  logic [HW-1:0] win_h1,
  input  logic [VW-1:0] win_v0,
  input  logic [VW-1:0] win_v1,
  input  logic [GW-1:0] up_gain,
  input  logic [CW-1:0] wanted,
  input  logic [YW-1:0] det_lo,
  input  logic [YW-1:0] det_hi,
  input  logic [YW+1:0] grey_lo,
  input  logic [YW+1:0] grey_hi,
  input  logic [CW-1:0] grey_min,
  output logic [FW-1:0] noise_fig,
  output logic [CW-1:0] detail_cnt,
  output logic [CW-1:0] grey_cnt
);

  localparam int SW = YW + 2;
  localparam int PW = FW + GW;
  localparam logic [FW-1:0] NF_MAX = '1;
  localparam logic [CW-1:0] C_MAX = '1;
  localparam logic [HW-1:0] H_MAX = '1;

  logic          lact;
  logic [VW-1:0] vcnt;
  logic [HW-1:0] hcnt, wpos;
  logic [YW-1:0] prev;
  logic [SW-1:0] acc_sad, acc_sum;
  logic [CW-1:0] cur_g, cur_a, blw_g, blw_a, grey_live, det_live;
  logic [FW-1:0] nf;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x, input logic en);
    return (en && x != C_MAX) ? x + 1'b1 : x;
  endfunction

  function automatic logic [SW-1:0] upper_of(input logic [FW-1:0] k, input logic [GW-1:0] g);
    logic [PW-1:0] prod;
    prod = PW'(k) * PW'(g);
    return SW'(k) + SW'(1) + SW'(prod >> 2);
  endfunction

  wire in_h  = hcnt >= win_h0 && hcnt <= win_h1;
  wire in_v  = vcnt >= win_v0 && vcnt <= win_v1;
  wire inwin = lact && pix_vld && in_h && in_v;

  wire [YW-1:0] dif = (pix_y >= prev) ? pix_y - prev : prev - pix_y;
  wire          past_first = |wpos[HW-1:2];
  wire          det_hit = inwin && past_first && dif >= det_lo && dif <= det_hi;

  wire [SW-1:0] sad_tot = acc_sad + SW'(dif);
  wire [SW-1:0] sum_tot = acc_sum + SW'(pix_y);
  wire          blk_done = inwin && past_first && wpos[1:0] == 2'd3;

  wire [FW-1:0] nf_blw = nf - 1'b1;
  wire          blw_ok = nf != '0;
  wire          is_grey = sum_tot >= grey_lo && sum_tot <= grey_hi;
  wire          hit_cur = blk_done && sad_tot >= SW'(nf) && sad_tot <= upper_of(nf, up_gain);
  wire          hit_blw = blk_done && blw_ok && sad_tot >= SW'(nf_blw) && sad_tot <= upper_of(nf_blw, up_gain);

  wire          grey_mode = grey_live >= grey_min;
  wire [CW-1:0] use_cur = grey_mode ? cur_g : cur_a;
  wire [CW-1:0] use_blw = grey_mode ? blw_g : blw_a;

  logic [FW-1:0] nf_next;
  always_comb begin
    nf_next = nf;
    if (blw_ok && use_blw >= wanted)        nf_next = nf - 1'b1;
    else if (use_cur < wanted && nf != NF_MAX) nf_next = nf + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lact <= 1'b0;
      vcnt <= '0;
      hcnt <= '0;
      wpos <= '0;
      prev <= '0;
      acc_sad <= '0;
      acc_sum <= '0;
      cur_g <= '0;
      cur_a <= '0;
      blw_g <= '0;
      blw_a <= '0;
      grey_live <= '0;
      det_live <= '0;
      nf <= '0;
      detail_cnt <= '0;
      grey_cnt <= '0;
    end else if (fsync) begin
      lact <= 1'b0;
      vcnt <= '0;
      hcnt <= '0;
      wpos <= '0;
      prev <= '0;
      cur_g <= '0;
      cur_a <= '0;
      blw_g <= '0;
      blw_a <= '0;
      grey_live <= '0;
      det_live <= '0;
      nf <= nf_next;
      detail_cnt <= det_live;
      grey_cnt <= grey_live;
    end else if (lsync) begin
      lact <= 1'b1;
      vcnt <= lact ? vcnt + 1'b1 : '0;
      hcnt <= '0;
      wpos <= '0;
      prev <= '0;
    end else if (pix_vld) begin
      hcnt <= (hcnt == H_MAX) ? hcnt : hcnt + 1'b1;
      prev <= pix_y;
      if (inwin) begin
        wpos <= (wpos == H_MAX) ? wpos : wpos + 1'b1;
        acc_sad <= (wpos[1:0] == 2'd0) ? SW'(dif) : sad_tot;
        acc_sum <= (wpos[1:0] == 2'd0) ? SW'(pix_y) : sum_tot;
        det_live <= sat_inc(det_live, det_hit);
        cur_a <= sat_inc(cur_a, hit_cur);
        cur_g <= sat_inc(cur_g, hit_cur && is_grey);
        blw_a <= sat_inc(blw_a, hit_blw);
        blw_g <= sat_inc(blw_g, hit_blw && is_grey);
        grey_live <= sat_inc(grey_live, blk_done && is_grey);
      end
    end
  end

  assign noise_fig = nf;

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (noise_fig == $past(noise_fig)) || (noise_fig == $past(noise_fig) + 1'b1) ||
              (noise_fig == $past(noise_fig) - 1'b1));

  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    fsync && noise_fig == NF_MAX |=> noise_fig != '0);

  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    fsync && noise_fig == '0 |=> noise_fig != NF_MAX);

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> $stable(noise_fig) && $stable(detail_cnt) && $stable(grey_cnt));

  a_r8_clear_counters: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> det_live == '0 && grey_live == '0 && cur_a == '0 && blw_a == '0);

  a_r7_detail_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    det_live == C_MAX && !fsync |=> det_live == C_MAX);

  a_r3_below_only_above_zero: assert property (@(posedge clk) disable iff (!rst_n)
    noise_fig == '0 && !fsync |=> blw_a == $past(blw_a));

endmodule

// File: tb/luma_noise_estimator_tb.sv
module luma_noise_estimator_tb;
  localparam int ML = 8;
  localparam int MP = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, fsync, lsync, pix_vld;
  logic [7:0]  pix_y;
  logic [10:0] win_h0, win_h1;
  logic [9:0]  win_v0, win_v1;
  logic [3:0]  up_gain;
  logic [15:0] wanted, grey_min;
  logic [7:0]  det_lo, det_hi;
  logic [9:0]  grey_lo, grey_hi;
  logic [3:0]  noise_fig;
  logic [15:0] detail_cnt, grey_cnt;

  luma_noise_estimator u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .lsync(lsync), .pix_vld(pix_vld),
    .pix_y(pix_y), .win_h0(win_h0), .win_h1(win_h1), .win_v0(win_v0), .win_v1(win_v1),
    .up_gain(up_gain), .wanted(wanted), .det_lo(det_lo), .det_hi(det_hi),
    .grey_lo(grey_lo), .grey_hi(grey_hi), .grey_min(grey_min),
    .noise_fig(noise_fig), .detail_cnt(detail_cnt), .grey_cnt(grey_cnt)
  );

  int pix[ML][MP];
  int nl, np;
  int exp_nf, exp_det, exp_grey;
  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int upb(input int k);
    return k + 1 + ((k * int'(up_gain)) >> 2);
  endfunction

  function automatic int absd(input int a, input int b);
    return (a >= b) ? a - b : b - a;
  endfunction

  task automatic model(output int cg, output int ca, output int bg, output int ba,
                       output int gr, output int dt);
    cg = 0; ca = 0; bg = 0; ba = 0; gr = 0; dt = 0;
    for (int v = 0; v < nl; v++) begin
      if (v < int'(win_v0) || v > int'(win_v1)) continue;
      for (int h = 0; h < np; h++) begin
        int wp, d;
        if (h < int'(win_h0) || h > int'(win_h1)) continue;
        wp = h - int'(win_h0);
        d = (h > 0) ? absd(pix[v][h], pix[v][h-1]) : pix[v][h];
        if (wp >= 4 && d >= int'(det_lo) && d <= int'(det_hi)) dt++;
        if (wp >= 4 && (wp % 4) == 3) begin
          int sad, sum;
          bit g;
          sad = 0; sum = 0;
          for (int i = h - 3; i <= h; i++) begin
            sad += absd(pix[v][i], pix[v][i-1]);
            sum += pix[v][i];
          end
          g = sum >= int'(grey_lo) && sum <= int'(grey_hi);
          if (g) gr++;
          if (sad >= exp_nf && sad <= upb(exp_nf)) begin
            ca++;
            if (g) cg++;
          end
          if (exp_nf > 0 && sad >= exp_nf - 1 && sad <= upb(exp_nf - 1)) begin
            ba++;
            if (g) bg++;
          end
        end
      end
    end
  endtask

  task automatic fill(input int base, input int amp);
    nl = 1 + $urandom_range(ML - 1);
    np = 8 + $urandom_range(MP - 8);
    for (int v = 0; v < ML; v++)
      for (int h = 0; h < MP; h++) begin
        int x;
        x = base + $urandom_range(2 * amp) - amp;
        pix[v][h] = (x < 0) ? 0 : (x > 255) ? 255 : x;
      end
  endtask

  task automatic send_field();
    for (int v = 0; v < nl; v++) begin
      @(negedge clk); lsync = 1'b1; pix_vld = 1'b0;
      @(negedge clk); lsync = 1'b0;
      for (int h = 0; h < np; h++) begin
        if ($urandom_range(4) == 0) begin
          pix_vld = 1'b0; pix_y = 8'($urandom);
          @(negedge clk);
        end
        pix_vld = 1'b1; pix_y = 8'(pix[v][h]);
        @(negedge clk);
      end
      pix_vld = 1'b0;
    end
  endtask

  task automatic close_field();
    int cg, ca, bg, ba, gr, dt, uc, ub;
    model(cg, ca, bg, ba, gr, dt);
    chk("R8 figure held during field", int'(noise_fig), exp_nf);
    chk("R8 detail held during field", int'(detail_cnt), exp_det);
    chk("R8 grey held during field", int'(grey_cnt), exp_grey);
    uc = (gr >= int'(grey_min)) ? cg : ca;
    ub = (gr >= int'(grey_min)) ? bg : ba;
    if (exp_nf > 0 && ub >= int'(wanted)) exp_nf--;
    else if (uc < int'(wanted) && exp_nf < 15) exp_nf++;
    exp_det = dt;
    exp_grey = gr;
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    chk("R3 R5 noise figure", int'(noise_fig), exp_nf);
    chk("R1 R2 R7 detail count", int'(detail_cnt), exp_det);
    chk("R2 R4 grey count", int'(grey_cnt), exp_grey);
  endtask

  task automatic rand_cfg();
    win_h0 = 11'($urandom_range(10));
    win_h1 = win_h0 + 11'($urandom_range(45));
    win_v0 = 10'($urandom_range(3));
    win_v1 = win_v0 + 10'($urandom_range(7));
    up_gain = 4'($urandom);
    wanted = 16'($urandom_range(12));
    det_lo = 8'($urandom_range(10));
    det_hi = det_lo + 8'($urandom_range(30));
    grey_lo = 10'($urandom_range(500));
    grey_hi = grey_lo + 10'($urandom_range(500));
    grey_min = 16'($urandom_range(20));
  endtask

  initial begin
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; fsync = 1'b0; lsync = 1'b0; pix_vld = 1'b0; pix_y = '0;
    rand_cfg();
    exp_nf = 0; exp_det = 0; exp_grey = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset figure", int'(noise_fig), 0);
    chk("R9 reset detail", int'(detail_cnt), 0);
    chk("R9 reset grey", int'(grey_cnt), 0);

    // R6 climb to the upper clamp with an unreachable wanted count
    rand_cfg(); wanted = 16'hFFFF;
    for (int f = 0; f < 18; f++) begin
      fill(40 + $urandom_range(150), 1 + $urandom_range(20));
      send_field();
      close_field();
    end
    chk("R6 upper clamp", int'(noise_fig), 15);

    // R6 descend to the lower clamp: any count meets a wanted of zero
    wanted = 16'd0;
    for (int f = 0; f < 17; f++) begin
      fill(40 + $urandom_range(150), 1 + $urandom_range(20));
      send_field();
      close_field();
    end
    chk("R6 lower clamp", int'(noise_fig), 0);

    // R1 window placed beyond every line: nothing counts
    rand_cfg(); win_v0 = 10'd20; win_v1 = 10'd30;
    fill(128, 10); send_field(); close_field();
    chk("R1 empty window detail", int'(detail_cnt), 0);

    // R2 a seven-pixel window holds only the skipped first group
    rand_cfg(); win_h0 = 11'd2; win_h1 = 11'd8; det_lo = 8'd0; det_hi = 8'd255;
    grey_lo = 10'd0; grey_hi = 10'd1023;
    fill(100, 30); send_field(); close_field();
    chk("R2 no complete block", int'(grey_cnt), 0);

    // R4 all-block mode forced by an unreachable grey threshold
    for (int f = 0; f < 8; f++) begin
      rand_cfg(); grey_min = 16'hFFFF; grey_lo = 10'd0; grey_hi = 10'd200;
      fill(20 + $urandom_range(200), $urandom_range(6));
      send_field(); close_field();
    end

    // mixed random fields, low noise to keep blocks near the tracked intervals
    for (int f = 0; f < 40; f++) begin
      rand_cfg();
      fill(20 + $urandom_range(215), $urandom_range(8));
      send_field(); close_field();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule